// File: doc/BRIEF.md
# Fan PWM Duty Cycle Generator

This block turns an 8-bit fan control register into a pulse-width-modulated drive for one fan pin. A 6-bit step counter runs through a period of 64 steps. The pin is high for as many steps as the 6-bit duty code in the register. A separate override bit in the register holds the pin fully high, whatever the duty code is.

The counter does not run on the system clock. It advances on clock-enable ticks. The top bit of the register picks which of two tick inputs is used. An external double-speed input picks the rate:
- When double speed is set, every selected tick advances the counter.
- When it is clear, every second selected tick advances the counter.

A newly written duty code waits until the counter wraps, so a period is never cut short or stretched in the middle. Software reads back the register through a separate data output.

Top module: `fan_pwm_gen`

## Requirements
- R1: After the asynchronous active-low reset, the control register is 0x00 and the fan pin is low.
- R2: A write loads `wr_data_i` into the control register, and `rd_data_o` shows the written byte from the next cycle on.
- R3: When register bit 0 (override) is 1, the fan pin is high from the cycle after the write, whatever bits 6:1 and the counter hold.
- R4: With override clear, a period is 64 counter steps, and the pin is high while the step index (0..63) is below the active duty code. Code 0 keeps the pin low, code 32 gives 32 high steps and 32 low steps, and code 63 gives 63 high steps and 1 low step.
- R5: The duty code in bits 6:1 becomes active only when the counter wraps from 63 to 0. A write in the middle of a period leaves the rest of that period unchanged. After reset the active code is 0.
- R6: Register bit 7 selects the tick source: 0 uses `tick_a_i` and 1 uses `tick_b_i`. Ticks on the unselected input have no effect on the pin.
- R7: When `dbl_i` is 1, every selected tick advances the counter. When it is 0, only every second selected tick advances it, and the first selected tick after reset does not.
- R8: In a cycle with no qualifying step, the counter and the pin level are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data: bit 7 selects the tick source, bits 6:1 hold the duty code, bit 0 is the override |
| tick_a_i | input | 1 | Clock-enable tick, source 0 |
| tick_b_i | input | 1 | Clock-enable tick, source 1 |
| dbl_i | input | 1 | Double speed: step on every selected tick |
| rd_data_o | output | 8 | Register readback |
| fan_o | output | 1 | Fan PWM pin |

## Verification
The duty cycle is tried with codes 0, 32 and 63. These separate the always-low case, the exact half split and the single low step at the end of a period, so an off-by-one in the compare or in the wrap shows up.

A code is written in the middle of a period, which separates a code that is applied at once from one that waits for the wrap. The override is written together with a nonzero duty code, so the override is seen to win over the compare.

Tick patterns vary in three ways:
- Ticks arrive on both inputs at different rates, which shows that only the selected source moves the counter.
- The halved rate is compared against the doubled rate.
- Idle stretches with no ticks check that the pin holds its level.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int unsigned DUTY_W = 6;
  localparam int unsigned REG_W  = DUTY_W + 2;
  localparam int unsigned STEPS  = 1 << DUTY_W;

  typedef struct packed {
    logic              src_sel;  // bit 7
    logic [DUTY_W-1:0] duty;     // bits 6:1
    logic              force_hi; // bit 0
  } fan_ctrl_t;
endpackage

// File: rtl/fan_ctrl_reg.sv
module fan_ctrl_reg
  import fan_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output fan_ctrl_t        ctrl_o
);
  fan_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= fan_ctrl_t'(wr_data_i);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/fan_tick_sel.sv
module fan_tick_sel #(
  parameter bit HALVE_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_a_i,
  input  logic tick_b_i,
  input  logic src_sel_i,
  input  logic dbl_i,
  output logic step_o
);
  logic sel_tick;

  assign sel_tick = src_sel_i ? tick_b_i : tick_a_i;

  generate
    if (HALVE_EN) begin : g_halve
      logic phase_q;

      // phase toggles on every selected tick; it gates the half-rate steps
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       phase_q <= 1'b0;
        else if (sel_tick) phase_q <= ~phase_q;
      end

      assign step_o = sel_tick & (dbl_i | phase_q);
    end else begin : g_direct
      logic unused_dbl;
      assign unused_dbl = dbl_i;
      assign step_o     = sel_tick;
    end
  endgenerate
endmodule

// File: rtl/fan_pwm_core.sv
module fan_pwm_core
  import fan_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              force_i,
  output logic [DUTY_W-1:0] cnt_o,
  output logic [DUTY_W-1:0] duty_act_o,
  output logic              fan_o
);
  logic [DUTY_W-1:0] cnt_q;
  logic [DUTY_W-1:0] duty_q;
  logic              wrap;

  assign wrap = step_i && (cnt_q == {DUTY_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  // duty is latched only at the period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   duty_q <= '0;
    else if (wrap) duty_q <= duty_i;
  end

  assign fan_o      = force_i | (cnt_q < duty_q);
  assign cnt_o      = cnt_q;
  assign duty_act_o = duty_q;
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pwm_pkg::*;
#(
  parameter bit HALVE_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             tick_a_i,
  input  logic             tick_b_i,
  input  logic             dbl_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             fan_o
);
  fan_ctrl_t         ctrl;
  logic              step_en;
  logic [DUTY_W-1:0] cnt;
  logic [DUTY_W-1:0] duty_act;

  fan_ctrl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .ctrl_o   (ctrl)
  );

  fan_tick_sel #(.HALVE_EN(HALVE_EN)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_a_i (tick_a_i),
    .tick_b_i (tick_b_i),
    .src_sel_i(ctrl.src_sel),
    .dbl_i    (dbl_i),
    .step_o   (step_en)
  );

  fan_pwm_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_en),
    .duty_i    (ctrl.duty),
    .force_i   (ctrl.force_hi),
    .cnt_o     (cnt),
    .duty_act_o(duty_act),
    .fan_o     (fan_o)
  );

  assign rd_data_o = ctrl;
endmodule

// File: rtl/fan_pwm_checker.sv
module fan_pwm_checker
  import fan_pwm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic [REG_W-1:0]  rd_data_o,
  input logic              fan_o,
  input logic              step_en,
  input logic [DUTY_W-1:0] cnt,
  input logic [DUTY_W-1:0] duty_act
);
  // R2
  a_r2_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i));

  // R3
  a_r3_force_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[0] |-> fan_o);

  // R4
  a_r4_last_step_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[0] && cnt == {DUTY_W{1'b1}}) |-> !fan_o);

  // R4
  a_r4_count_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en |=> cnt == $past(cnt) + 1'b1);

  // R5
  a_r5_duty_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_en && cnt == {DUTY_W{1'b1}}) |=> $stable(duty_act));

  // R8
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_en && !wr_en_i) |=> ($stable(cnt) && $stable(fan_o)));
endmodule

bind fan_pwm_gen fan_pwm_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .fan_o    (fan_o),
  .step_en  (step_en),
  .cnt      (cnt),
  .duty_act (duty_act)
);

// File: tb/tb_fan_pwm_gen.sv
module tb_fan_pwm_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       tick_a_i = 1'b0;
  logic       tick_b_i = 1'b0;
  logic       dbl_i = 1'b1;
  logic [7:0] rd_data_o;
  logic       fan_o;

  always #5 clk_i = ~clk_i;

  fan_pwm_gen dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .tick_a_i (tick_a_i),
    .tick_b_i (tick_b_i),
    .dbl_i    (dbl_i),
    .rd_data_o(rd_data_o),
    .fan_o    (fan_o)
  );

  typedef struct {
    int         cyc;
    logic       fan;
    logic [7:0] rd;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;

  // requirement-level reference state
  logic [7:0] m_ctrl  = '0;
  int         m_step  = 0;
  int         m_duty  = 0;
  bit         m_phase = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compare scheduled expectations
  always @(negedge clk_i) begin
    while (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (fan_o !== it.fan || rd_data_o !== it.rd) begin
        n_fail++;
        $display("FAIL %s cyc %0d: fan=%b rd=%h expected fan=%b rd=%h",
                 it.tag, cyc, fan_o, rd_data_o, it.fan, it.rd);
      end
    end
  end

  // driver: one cycle of stimulus, expectation pushed for the next cycle
  task automatic drive(input bit wr, input logic [7:0] d, input bit ta,
                       input bit tb, input bit dbl, input string tag);
    bit sel, stp;
    item_t it;
    @(posedge clk_i); #1;
    wr_en_i = wr; wr_data_i = d; tick_a_i = ta; tick_b_i = tb; dbl_i = dbl;
    sel = m_ctrl[7] ? tb : ta;           // R6
    stp = sel && (dbl || m_phase);       // R7
    if (sel) m_phase = ~m_phase;
    if (stp) begin                       // R4, R5
      if (m_step == 63) begin m_step = 0; m_duty = int'(m_ctrl[6:1]); end
      else m_step++;
    end
    if (wr) m_ctrl = d;                  // R2
    it.cyc = cyc + 1;
    it.fan = m_ctrl[0] || (m_step < m_duty); // R3, R4
    it.rd  = m_ctrl;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic run(input int n, input int a_every, input int b_every,
                     input bit dbl, input string tag);
    for (int i = 0; i < n; i++)
      drive(1'b0, 8'h00, (a_every > 0) && (i % a_every == 0),
            (b_every > 0) && (i % b_every == 0), dbl, tag);
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    drive(1'b1, d, 1'b0, 1'b0, 1'b1, tag);
  endtask

  int high_cnt;

  initial begin : watchdog
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (fan_o !== 1'b0 || rd_data_o !== 8'h00) begin
      n_fail++;
      $display("FAIL R1 reset: fan=%b rd=%h expected fan=0 rd=00", fan_o, rd_data_o);
    end
    rst_ni = 1'b1;

    // R2 readback, R5 first period still at reset code 0
    wr(8'h40, "R2");
    run(64, 1, 0, 1'b1, "R5_reset_code");
    // R4 code 32: count high steps over a period
    high_cnt = 0;
    for (int i = 0; i < 64; i++) begin
      drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R4_half");
      @(negedge clk_i);
      if (fan_o) high_cnt++;
    end
    n_chk++;
    if (high_cnt != 32) begin
      n_fail++;
      $display("FAIL R4 half duty: high=%0d expected 32", high_cnt);
    end

    // R5 mid-period write of code 63
    run(20, 1, 0, 1'b1, "R4");
    wr(8'h7E, "R5_mid");
    run(140, 1, 0, 1'b1, "R5_mid");

    // R4 code 63 high-step count on an aligned period (step index at 0 now? count anyway)
    high_cnt = 0;
    for (int i = 0; i < 64; i++) begin
      drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R4_max");
      @(negedge clk_i);
      if (fan_o) high_cnt++;
    end
    n_chk++;
    if (high_cnt != 63) begin
      n_fail++;
      $display("FAIL R4 max duty: high=%0d expected 63", high_cnt);
    end

    // R4 code 0
    wr(8'h00, "R4_zero");
    run(130, 1, 0, 1'b1, "R4_zero");

    // R3 override with duty 32
    wr(8'h41, "R3");
    run(80, 1, 0, 1'b1, "R3");
    wr(8'h40, "R3_release");
    run(70, 1, 0, 1'b1, "R3_release");

    // R6 source b, tick a busy
    wr(8'hC0, "R6");
    run(200, 1, 3, 1'b1, "R6");
    wr(8'h20, "R6_a");
    run(200, 2, 1, 1'b1, "R6_a");

    // R7 halved rate
    run(300, 1, 0, 1'b0, "R7");
    run(150, 3, 0, 1'b0, "R7_sparse");

    // R8 idle
    run(40, 0, 0, 1'b1, "R8");
    run(40, 0, 1, 1'b1, "R8_unsel");

    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R8");
    repeat (3) @(negedge clk_i);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: %0d items left expected 0", sb_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule